// File: doc/BRIEF.md
# Timer Interrupt Flag Register with Fast Clear

This block keeps the pending-event flags of an eight-channel, 16-bit timer. Each capture/compare channel has one flag. A further flag records wraps of the free-running counter. A channel event pulse sets that channel's flag, and a counter-wrap pulse sets the overflow flag. Software reads the flags through two byte-wide registers on a simple register bus, which has an address, a read strobe, a write strobe and 8-bit write data.

Software has two ways to clear a flag. The first is to write a one to the flag's bit position. The second needs the fast-clear input to be high. In that mode, an ordinary data access clears a flag as a side effect: any access to the counter clears the overflow flag, a read of a capture channel's high data byte clears that channel's flag, and a write of a compare channel's high data byte clears that channel's flag. Each flag drives an interrupt output. That output is the flag ANDed with a per-flag enable and then registered.

Top module: `tfc_flags`

## Requirements
- R1: After synchronous reset, every flag and every interrupt output is zero, and both flag registers read 0x00.
- R2: A one-cycle pulse on `chan_evt[x]` sets channel flag x. The flag shows as bit x of the channel flag register (offset 0x0E) after the next rising clock edge and stays set until it is cleared.
- R3: A one-cycle pulse on `ovf_evt` sets the overflow flag. The flag reads as bit 7 of the overflow flag register (offset 0x0F), and bits 6:0 of that register always read zero.
- R4: A write to offset 0x0E clears every channel flag whose data bit is one and leaves the others unchanged. A write to 0x0F with bit 7 set clears the overflow flag, and a write with bit 7 clear leaves it unchanged.
- R5: While `fast_clr` is low, accesses to the counter (0x04, 0x05) and to the channel data bytes (0x10 to 0x1F) change no flag.
- R6: While `fast_clr` is high, a read or a write at either counter byte (0x04 or 0x05) clears the overflow flag.
- R7: While `fast_clr` is high and channel x is in capture mode (`chan_oc[x]` = 0), a read of its high data byte at 0x10 + 2x clears flag x. A write to that byte does not clear flag x, and neither does any access to its low byte at 0x11 + 2x.
- R8: While `fast_clr` is high and channel x is in compare mode (`chan_oc[x]` = 1), a write of its high data byte at 0x10 + 2x clears flag x. A read of that byte does not clear flag x, and neither does any access to its low byte.
- R9: When a set pulse and a clear of the same flag fall in the same cycle, the set wins and the flag ends up set. This holds for both explicit and fast clears.
- R10: Each interrupt output equals its flag ANDed with its enable, registered once. It therefore rises one cycle after the flag it follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the flag registers, zero elsewhere |
| fast_clr | input | 1 | Fast-clear mode enable |
| chan_oc | input | 8 | Per-channel mode: 1 compare, 0 capture |
| chan_evt | input | 8 | Per-channel capture/compare event pulses |
| ovf_evt | input | 1 | Counter wrap pulse |
| chan_ie | input | 8 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| chan_irq | output | 8 | Per-channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, a 6-bit address, the counter at 0x04 and the channel data at 0x10. With eight channels, every flag bit and every channel address is reachable. The bench sweeps every channel in both modes, reading and writing both the high and the low data byte, with fast clear both on and off. For each case it computes the expected flag byte as all ones minus the single bit the access should clear. It also drives set pulses in the same cycle as explicit and fast clears, and walks a pattern of interrupt enables.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        CH_CAPTURE = 1'b0,
        CH_COMPARE = 1'b1
    } ch_mode_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    // Offset of the high data byte of a channel
    function automatic int chan_hi_off(input int base, input int idx);
        return base + 2 * idx;
    endfunction

endpackage

// File: rtl/tfc_clr_decode.sv
module tfc_clr_decode
    import tfc_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int AW        = 6,
    parameter int FLG1_ADDR = 'h0E,
    parameter int FLG2_ADDR = 'h0F,
    parameter int CNT_ADDR  = 'h04,
    parameter int CH_BASE   = 'h10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  addr,
    input  bus_req_t       req,
    input  logic           fast_en,
    input  logic [NCH-1:0] chan_oc,
    output logic [NCH-1:0] chan_clr,
    output logic           ovf_clr
);

    logic           wr_flg1;
    logic           wr_flg2;
    logic           cnt_hit;
    logic [NCH-1:0] fast_vec;
    logic           ovf_fast;

    always_comb begin
        wr_flg1  = req.wr && (addr == AW'(FLG1_ADDR));
        wr_flg2  = req.wr && (addr == AW'(FLG2_ADDR));
        cnt_hit  = (addr == AW'(CNT_ADDR)) || (addr == AW'(CNT_ADDR + 1));
        ovf_fast = fast_en && cnt_hit && (req.rd || req.wr);
        ovf_clr  = (wr_flg2 && req.wdata[BYTE_W-1]) || ovf_fast;
    end

    for (genvar x = 0; x < NCH; x++) begin : g_ch
        logic hi_hit;
        logic dir_ok;
        always_comb begin
            hi_hit      = (addr == AW'(chan_hi_off(CH_BASE, x)));
            dir_ok      = (ch_mode_e'(chan_oc[x]) == CH_COMPARE) ? req.wr : req.rd;
            fast_vec[x] = fast_en && hi_hit && dir_ok;
            chan_clr[x] = (wr_flg1 && req.wdata[x]) || fast_vec[x];
        end
    end

    // R7 / R8: one address selects at most one channel for fast clear
    a_r7_fast_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fast_vec));

    // R5: with fast clear off, no side-effect clear occurs
    a_r5_no_fast_off: assert property (@(posedge clk) disable iff (rst)
        !fast_en |-> (fast_vec == '0 && !ovf_fast));

    // R8: a read never triggers a compare-mode fast clear
    a_r8_rd_no_oc_clr: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !req.wr) |-> ((fast_vec & chan_oc) == '0));

endmodule

// File: rtl/tfc_read_mux.sv
module tfc_read_mux
    import tfc_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int AW        = 6,
    parameter int FLG1_ADDR = 'h0E,
    parameter int FLG2_ADDR = 'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [NCH-1:0]    chan_flag,
    input  logic              ovf_flag,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == AW'(FLG1_ADDR)) begin
            for (int i = 0; i < NCH; i++) rdata[i] = chan_flag[i];
        end else if (addr == AW'(FLG2_ADDR)) begin
            rdata[BYTE_W-1] = ovf_flag;
        end
    end

    // R3: unused bits of the overflow register read zero
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == AW'(FLG2_ADDR)) |-> (rdata[BYTE_W-2:0] == '0));

endmodule

// File: rtl/tfc_flag_cell.sv
module tfc_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
            irq  <= flag & ie;
        end
    end

    // R9: a set pulse always leaves the flag high
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R4: a clear with no set drops the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R2: with neither set nor clear, the flag holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(flag));

    // R10: the request follows flag and enable one cycle later
    a_r10_irq_lag: assert property (@(posedge clk) disable iff (rst)
        (flag && ie) |=> irq);

endmodule

// File: rtl/tfc_flags.sv
module tfc_flags
    import tfc_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int AW        = 6,
    parameter int FLG1_ADDR = 'h0E,
    parameter int FLG2_ADDR = 'h0F,
    parameter int CNT_ADDR  = 'h04,
    parameter int CH_BASE   = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              fast_clr,
    input  logic [NCH-1:0]    chan_oc,
    input  logic [NCH-1:0]    chan_evt,
    input  logic              ovf_evt,
    input  logic [NCH-1:0]    chan_ie,
    input  logic              ovf_ie,
    output logic [NCH-1:0]    chan_irq,
    output logic              ovf_irq
);

    localparam int NFLAG = NCH + 1;
    localparam int OVF_IX = NCH;

    bus_req_t         req;
    logic [NCH-1:0]   chan_clr;
    logic             ovf_clr;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] ie_v;
    logic [NFLAG-1:0] flag_v;
    logic [NFLAG-1:0] irq_v;

    always_comb begin
        req.rd    = bus_rd;
        req.wr    = bus_wr;
        req.wdata = bus_wdata;
        set_v     = {ovf_evt, chan_evt};
        clr_v     = {ovf_clr, chan_clr};
        ie_v      = {ovf_ie, chan_ie};
    end

    tfc_clr_decode #(
        .NCH(NCH), .AW(AW), .FLG1_ADDR(FLG1_ADDR), .FLG2_ADDR(FLG2_ADDR),
        .CNT_ADDR(CNT_ADDR), .CH_BASE(CH_BASE)
    ) u_decode (
        .clk(clk), .rst(rst), .addr(bus_addr), .req(req),
        .fast_en(fast_clr), .chan_oc(chan_oc),
        .chan_clr(chan_clr), .ovf_clr(ovf_clr)
    );

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        tfc_flag_cell u_cell (
            .clk(clk), .rst(rst), .set(set_v[f]), .clr(clr_v[f]),
            .ie(ie_v[f]), .flag(flag_v[f]), .irq(irq_v[f])
        );
    end

    tfc_read_mux #(
        .NCH(NCH), .AW(AW), .FLG1_ADDR(FLG1_ADDR), .FLG2_ADDR(FLG2_ADDR)
    ) u_rmux (
        .clk(clk), .rst(rst), .addr(bus_addr),
        .chan_flag(flag_v[NCH-1:0]), .ovf_flag(flag_v[OVF_IX]),
        .rdata(bus_rdata)
    );

    always_comb begin
        chan_irq = irq_v[NCH-1:0];
        ovf_irq  = irq_v[OVF_IX];
    end

    // R1: reset leaves all requests low on the following cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (chan_irq == '0 && !ovf_irq));

endmodule

// File: tb/tfc_flags_bench.sv
module tfc_flags_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       fast_clr = 1'b0;
    logic [7:0] chan_oc = '0;
    logic [7:0] chan_evt = '0;
    logic       ovf_evt = 1'b0;
    logic [7:0] chan_ie = '0;
    logic       ovf_ie = 1'b0;
    logic [7:0] chan_irq;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tfc_flags u_tfc_flags (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_clr(fast_clr), .chan_oc(chan_oc), .chan_evt(chan_evt),
        .ovf_evt(ovf_evt), .chan_ie(chan_ie), .ovf_ie(ovf_ie),
        .chan_irq(chan_irq), .ovf_irq(ovf_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bus cycle plus event pulses, starting and ending at a falling edge
    task automatic cyc(input logic [5:0] a, input logic rd, input logic wr,
                       input logic [7:0] d, input logic [7:0] ev, input logic ov);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        chan_evt = ev; ovf_evt = ov;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        chan_evt = '0; ovf_evt = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd_reg(6'h0E, v); check("R1 flg1", v, 8'h00);
        rd_reg(6'h0F, v); check("R1 flg2", v, 8'h00);
        check("R1 irq", {ovf_irq, chan_irq[6:0]}, 8'h00);

        // R2 / R4: each channel sets alone and clears by write-one
        for (int x = 0; x < 8; x++) begin
            cyc(6'h00, 0, 0, 0, 8'(1 << x), 0);
            rd_reg(6'h0E, v); check("R2 set", v, 8'(1 << x));
            cyc(6'h0E, 0, 1, 8'(1 << x), 0, 0);
            rd_reg(6'h0E, v); check("R4 clr", v, 8'h00);
        end

        // R4: write-zero leaves, partial masks
        cyc(6'h00, 0, 0, 0, 8'hFF, 0);
        cyc(6'h0E, 0, 1, 8'h00, 0, 0);
        rd_reg(6'h0E, v); check("R4 zero", v, 8'hFF);
        cyc(6'h0E, 0, 1, 8'h55, 0, 0);
        rd_reg(6'h0E, v); check("R4 mask", v, 8'hAA);
        cyc(6'h0E, 0, 1, 8'hAA, 0, 0);
        rd_reg(6'h0E, v); check("R4 rest", v, 8'h00);

        // R3 / R4: overflow flag
        cyc(6'h00, 0, 0, 0, 0, 1);
        rd_reg(6'h0F, v); check("R3 ovf", v, 8'h80);
        cyc(6'h0F, 0, 1, 8'h7F, 0, 0);
        rd_reg(6'h0F, v); check("R4 ovf keep", v, 8'h80);
        cyc(6'h0F, 0, 1, 8'h80, 0, 0);
        rd_reg(6'h0F, v); check("R4 ovf clr", v, 8'h00);

        // R5: fast clear off, every data access leaves flags
        cyc(6'h00, 0, 0, 0, 8'hFF, 1);
        for (int m = 0; m < 2; m++) begin
            chan_oc = m[0] ? 8'hFF : 8'h00;
            for (int a = 6'h10; a < 6'h20; a++) begin
                cyc(6'(a), 1, 0, 0, 0, 0);
                cyc(6'(a), 0, 1, 8'hFF, 0, 0);
            end
            cyc(6'h04, 1, 0, 0, 0, 0);
            cyc(6'h05, 0, 1, 8'hFF, 0, 0);
        end
        rd_reg(6'h0E, v); check("R5 chan", v, 8'hFF);
        rd_reg(6'h0F, v); check("R5 ovf", v, 8'h80);

        // R6: fast clear on counter accesses
        fast_clr = 1'b1;
        for (int a = 4; a < 6; a++) begin
            for (int op = 0; op < 2; op++) begin
                cyc(6'h00, 0, 0, 0, 0, 1);
                cyc(6'(a), op == 0, op == 1, 8'h00, 0, 0);
                rd_reg(6'h0F, v); check("R6 cnt", v, 8'h00);
            end
        end

        // R7 / R8: sweep channels, modes, directions, bytes
        for (int m = 0; m < 2; m++) begin
            chan_oc = m[0] ? 8'hFF : 8'h00;
            for (int x = 0; x < 8; x++) begin
                for (int op = 0; op < 2; op++) begin
                    for (int lo = 0; lo < 2; lo++) begin
                        logic hit;
                        cyc(6'h00, 0, 0, 0, 8'hFF, 0);
                        cyc(6'(6'h10 + 2 * x + lo), op == 0, op == 1, 8'h00, 0, 0);
                        hit = (lo == 0) && ((op == 0 && m == 0) || (op == 1 && m == 1));
                        rd_reg(6'h0E, v);
                        check(m == 0 ? "R7 capture" : "R8 compare", v,
                              hit ? 8'(~(1 << x)) : 8'hFF);
                        cyc(6'h0E, 0, 1, 8'hFF, 0, 0);
                    end
                end
            end
        end

        // R9: set beats simultaneous explicit and fast clears
        cyc(6'h0E, 0, 1, 8'hFF, 8'h0F, 0);
        rd_reg(6'h0E, v); check("R9 explicit", v, 8'h0F);
        chan_oc = 8'h00;
        cyc(6'h12, 1, 0, 0, 8'h02, 0);
        rd_reg(6'h0E, v); check("R9 fast", v, 8'h0F);
        cyc(6'h04, 1, 0, 0, 0, 1);
        rd_reg(6'h0F, v); check("R9 ovf", v, 8'h80);
        cyc(6'h0E, 0, 1, 8'hFF, 0, 0);
        cyc(6'h0F, 0, 1, 8'h80, 0, 0);
        fast_clr = 1'b0;

        // R10: interrupt timing and enable masking
        chan_ie = 8'h33; ovf_ie = 1'b1;
        @(negedge clk);
        cyc(6'h00, 0, 0, 0, 8'hFF, 1);
        check("R10 lag", chan_irq, 8'h00);
        @(negedge clk);
        check("R10 chan", chan_irq, 8'h33);
        check("R10 ovf", {7'h0, ovf_irq}, 8'h01);
        cyc(6'h0E, 0, 1, 8'h01, 0, 0);
        @(negedge clk);
        check("R10 drop", chan_irq, 8'h32);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule